// File: doc/BRIEF.md
# Receive Low-Power-Idle Exit Interrupt Flag

This block raises an interrupt when an Ethernet receive link comes out of low-power idle. It spans two clock domains. On the receive side it samples the PHY's idle indication, and on a high-to-low transition of that indication it sets a sticky flag. On the register side, software clears the flag by reading the low-power control/status register. That read toggles a request bit. A toggle synchroniser carries the request into the receive domain, and the flag drops there.

The flag can only clear while the receive clock is running, because the clear is registered in the receive domain. If the PHY stops that clock before the clear arrives, the flag and the combined interrupt stay high until the clock comes back. A copy of the flag is synchronised into the register domain and serves as a readable status bit. The flag has no mask. It is ORed with the MAC host interrupt and with the reductions of the receive-channel and transmit-channel interrupt vectors to form the single external interrupt line.

Top module: `lpi_wake_irq_ctl`

## Requirements
- R1: When both resets are asserted, `wake_flag`, `wake_sts` and `mac_irq` are 0, provided the other interrupt sources are 0. Reset also clears a flag that was already set.
- R2: If `phy_lpi` is sampled 1 on one `rx_clk` edge and 0 on the next, `wake_flag` is 1 after that second edge.
- R3: Once set, `wake_flag` stays 1 through later idle entries and exits for as long as no register read clears it.
- R4: A read is a `lpi_csr_rd` high on one `csr_clk` edge. After that edge, `wake_flag` is still 1 after three `rx_clk` rising edges and is 0 after the fourth, provided no new exit occurs.
- R5: If `rx_clk` stops after a read, `wake_flag` and `mac_irq` stay 1 however many `csr_clk` cycles pass. Once `rx_clk` resumes, `wake_flag` falls on the fourth rising edge.
- R6: If an exit is detected on the same `rx_clk` edge at which a clear takes effect, the set wins and `wake_flag` stays 1.
- R7: `wake_sts` follows `wake_flag` through two `csr_clk` flops. It is still 0 after the first `csr_clk` edge following the set and is 1 after the second.
- R8: `mac_irq` is 1 exactly when any of these is 1: `wake_flag`, `core_irq`, any bit of `rxq_irq`, any bit of `txq_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive clock from the PHY; may stop during idle |
| rx_rst_n | input | 1 | Active-low asynchronous reset, receive domain |
| phy_lpi | input | 1 | PHY low-power-idle indication, synchronous to rx_clk |
| csr_clk | input | 1 | Register access clock |
| csr_rst_n | input | 1 | Active-low asynchronous reset, register domain |
| lpi_csr_rd | input | 1 | One-cycle strobe: the low-power control/status register is read |
| core_irq | input | 1 | MAC host interrupt |
| rxq_irq | input | NRX | Receive channel interrupts |
| txq_irq | input | NTX | Transmit channel interrupts |
| wake_flag | output | 1 | Sticky exit interrupt, receive domain |
| wake_sts | output | 1 | Exit status bit, synchronised into the register domain |
| mac_irq | output | 1 | Combined external interrupt line |

## Verification
Three kinds of fault are targeted. If the receive-side clear path has the wrong depth, the flag falls one `rx_clk` edge early or late relative to the read, so the bench samples the flag after both the third and the fourth edge. If set and clear are given the wrong priority, the flag drops after an exit that coincides with a clear, and the loss is visible at `wake_flag` and `mac_irq` on the very next receive edge. If the toggle is lost or the synchroniser is bypassed, the flag either never drops or drops while `rx_clk` is held still; both show up during the stopped-clock window.

// File: rtl/lpi_wake_pkg.sv
package lpi_wake_pkg;

  localparam int SYNC_STAGES_DEF = 2;

  // Combine the exit flag with the reduced MAC interrupt groups.
  function automatic logic irq_merge(input logic wake, input logic core,
                                     input logic rx_any, input logic tx_any);
    return wake | core | rx_any | tx_any;
  endfunction

endpackage

// File: rtl/lpi_exit_flag.sv
module lpi_exit_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic lpi,
  input  logic clr,
  output logic flag,
  output logic exit_evt
);

  logic lpi_q;

  // Idle seen last cycle, active now: the link has left idle.
  assign exit_evt = lpi_q & ~lpi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lpi_q <= 1'b0;
      flag  <= 1'b0;
    end else begin
      lpi_q <= lpi;
      if (exit_evt)
        flag <= 1'b1;        // set has priority over clear
      else if (clr)
        flag <= 1'b0;
    end
  end

  a_r2_exit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |=> flag);

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_evt && clr) |=> flag);

  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !exit_evt) |=> !flag);

  a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!exit_evt && !clr) |=> $stable(flag));

endmodule

// File: rtl/clr_pulse_xing.sv
module clr_pulse_xing #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);

  logic              tgl;
  logic [STAGES-1:0] sync;
  logic              hist;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n)
      tgl <= 1'b0;
    else if (src_pulse)
      tgl <= ~tgl;
  end

  // The toggle waits here while dst_clk is stopped; no edge means no clear.
  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      sync      <= '0;
      hist      <= 1'b0;
      dst_pulse <= 1'b0;
    end else begin
      sync      <= {sync[STAGES-2:0], tgl};
      hist      <= sync[STAGES-1];
      dst_pulse <= sync[STAGES-1] ^ hist;
    end
  end

  a_r4_toggle_flips: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_pulse |=> (tgl != $past(tgl)));

endmodule

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      chain <= '0;
    else
      chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/lpi_wake_irq_ctl.sv
module lpi_wake_irq_ctl #(
  parameter int NRX         = 5,
  parameter int NTX         = 5,
  parameter int SYNC_STAGES = lpi_wake_pkg::SYNC_STAGES_DEF
) (
  input  logic           rx_clk,
  input  logic           rx_rst_n,
  input  logic           phy_lpi,
  input  logic           csr_clk,
  input  logic           csr_rst_n,
  input  logic           lpi_csr_rd,
  input  logic           core_irq,
  input  logic [NRX-1:0] rxq_irq,
  input  logic [NTX-1:0] txq_irq,
  output logic           wake_flag,
  output logic           wake_sts,
  output logic           mac_irq
);

  logic clr_rx;     // clear request, now in the receive domain
  logic exit_evt;   // idle exit seen this receive cycle

  clr_pulse_xing #(.STAGES(SYNC_STAGES)) u_clr_xing (
    .src_clk   (csr_clk),
    .src_rst_n (csr_rst_n),
    .src_pulse (lpi_csr_rd),
    .dst_clk   (rx_clk),
    .dst_rst_n (rx_rst_n),
    .dst_pulse (clr_rx)
  );

  lpi_exit_flag u_flag (
    .clk      (rx_clk),
    .rst_n    (rx_rst_n),
    .lpi      (phy_lpi),
    .clr      (clr_rx),
    .flag     (wake_flag),
    .exit_evt (exit_evt)
  );

  bit_sync #(.STAGES(SYNC_STAGES)) u_sts_sync (
    .clk   (csr_clk),
    .rst_n (csr_rst_n),
    .d     (wake_flag),
    .q     (wake_sts)
  );

  assign mac_irq = lpi_wake_pkg::irq_merge(wake_flag, core_irq, |rxq_irq, |txq_irq);

  a_r2_flag_rises_on_exit: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    $rose(wake_flag) |-> $past(exit_evt));

endmodule

// File: tb/lpi_wake_irq_ctl_tb.sv
module lpi_wake_irq_ctl_tb;

  localparam int NRX = 5;
  localparam int NTX = 5;

  logic rx_clk = 1'b0, csr_clk = 1'b1, rx_run = 1'b1;
  logic rx_rst_n = 1'b0, csr_rst_n = 1'b0;
  logic phy_lpi = 1'b0, lpi_csr_rd = 1'b0, core_irq = 1'b0;
  logic [NRX-1:0] rxq_irq = '0;
  logic [NTX-1:0] txq_irq = '0;
  logic wake_flag, wake_sts, mac_irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  // 125 MHz; csr_clk rises half a period after rx_clk
  always #4 rx_clk = rx_run ? ~rx_clk : rx_clk;
  always #4 csr_clk = ~csr_clk;

  lpi_wake_irq_ctl #(.NRX(NRX), .NTX(NTX)) u_dut (
    .rx_clk, .rx_rst_n, .phy_lpi, .csr_clk, .csr_rst_n, .lpi_csr_rd,
    .core_irq, .rxq_irq, .txq_irq, .wake_flag, .wake_sts, .mac_irq
  );

  // {core, rxq[4:0], txq[4:0], expected mac_irq} with the flag at 0
  localparam logic [11:0] VEC [8] = '{
    {1'b0, 5'b00000, 5'b00000, 1'b0},
    {1'b1, 5'b00000, 5'b00000, 1'b1},
    {1'b0, 5'b00001, 5'b00000, 1'b1},
    {1'b0, 5'b10000, 5'b00000, 1'b1},
    {1'b0, 5'b00000, 5'b00100, 1'b1},
    {1'b0, 5'b00000, 5'b10000, 1'b1},
    {1'b1, 5'b01010, 5'b00011, 1'b1},
    {1'b0, 5'b00000, 5'b00000, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic csr_read();
    @(negedge csr_clk) lpi_csr_rd = 1'b1;
    @(negedge csr_clk) lpi_csr_rd = 1'b0;
  endtask

  task automatic lpi_exit();
    @(negedge rx_clk) phy_lpi = 1'b1;
    @(negedge rx_clk) phy_lpi = 1'b0;
    @(negedge rx_clk);
  endtask

  task automatic rx_wait(input int n);
    repeat (n) @(negedge rx_clk);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #20;
    chk("R1 reset flag", wake_flag, 1'b0);
    chk("R1 reset sts", wake_sts, 1'b0);
    chk("R1 reset irq", mac_irq, 1'b0);
    @(negedge rx_clk) begin rx_rst_n = 1'b1; csr_rst_n = 1'b1; end
    rx_wait(2);

    // R8 vector table, flag at 0
    for (int i = 0; i < 8; i++) begin
      {core_irq, rxq_irq, txq_irq} = VEC[i][11:1];
      #1 chk("R8 or", mac_irq, VEC[i][0]);
    end

    // R2 exit sets; R7 status latency
    @(negedge rx_clk) phy_lpi = 1'b1;
    @(negedge rx_clk) phy_lpi = 1'b0;
    #10;
    chk("R2 set", wake_flag, 1'b1);
    chk("R8 flag alone", mac_irq, 1'b1);
    chk("R7 sts one edge", wake_sts, 1'b0);
    #8 chk("R7 sts two edges", wake_sts, 1'b1);

    // R3 sticky over further idle cycles
    lpi_exit();
    rx_wait(5);
    chk("R3 sticky", wake_flag, 1'b1);

    // R4 clear timing
    csr_read();
    rx_wait(3);
    chk("R4 three edges", wake_flag, 1'b1);
    rx_wait(1);
    chk("R4 four edges", wake_flag, 1'b0);
    chk("R4 irq low", mac_irq, 1'b0);

    // R6 exit coincides with clear
    lpi_exit();
    @(negedge rx_clk) phy_lpi = 1'b1;
    csr_read();
    rx_wait(3);
    chk("R6 before", wake_flag, 1'b1);
    phy_lpi = 1'b0;
    rx_wait(1);
    chk("R6 set wins", wake_flag, 1'b1);
    rx_wait(2);
    chk("R6 still set", wake_flag, 1'b1);

    // R5 stopped receive clock
    @(negedge rx_clk) rx_run = 1'b0;
    csr_read();
    repeat (20) @(negedge csr_clk);
    chk("R5 flag held", wake_flag, 1'b1);
    chk("R5 irq held", mac_irq, 1'b1);
    @(posedge csr_clk);
    #2 rx_run = 1'b1;
    rx_wait(3);
    chk("R5 three after restart", wake_flag, 1'b1);
    rx_wait(1);
    chk("R5 four after restart", wake_flag, 1'b0);

    // R1 reset clears a set flag
    lpi_exit();
    repeat (3) @(negedge csr_clk);
    @(negedge rx_clk) begin rx_rst_n = 1'b0; csr_rst_n = 1'b0; end
    #1;
    chk("R1 reset clears flag", wake_flag, 1'b0);
    chk("R1 reset clears sts", wake_sts, 1'b0);
    chk("R1 reset clears irq", mac_irq, 1'b0);

    finished = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule